// File: doc/BRIEF.md
# RF phase measurement counter

This block measures where a signal edge falls inside one RF cycle and reports it in milli-cycles. It runs from a phase clock that is a fixed multiple (default 1000) of the signal frequency. A rising edge on the reference strobe starts a count. The next rising edge on the signal input stops it. The count reached is captured as the phase result, which runs from 1 to 999. If no signal edge arrives by the last count of the cycle, the result is pinned at 999 and a stale flag is raised. Every capture raises an interrupt request at priority level 5.

Software reads the result as two bytes through a byte-wide read port. Reading the low byte copies the upper bits and the stale flag into a hold register. The high-byte read that follows returns that copy, so the two halves always belong to the same measurement, even when a new capture lands between the two reads. The assembled value is the low byte plus the high byte's lower nibble shifted left by 8.

Top module: `phase_meter`

## Requirements
- R1: After a rising edge of `ref_i`, a rising edge of `sig_i` k phase clocks later (1 ≤ k ≤ 999) captures the result k.
- R2: If no rising edge of `sig_i` arrives by count 999, the result is 999 and the stale flag is set. A signal edge at exactly count 999 gives 999 with the stale flag clear. Each capture writes the stale flag anew.
- R3: A rising edge of `ref_i` during a running measurement restarts the count from that edge.
- R4: A rising edge of `sig_i` while no measurement is running is ignored: the stored result stays as it was and `irq_o` is not raised.
- R5: A low-byte read (`rd_i`=1, `rd_hi_i`=0) returns result bits 7:0. In the same cycle it copies result bits 11:8 and the stale flag into the hold register.
- R6: A high-byte read (`rd_i`=1, `rd_hi_i`=1) returns {held stale flag in bit 7, zeros in bits 6:4, held result bits 11:8 in bits 3:0}.
- R7: When a capture and a low-byte read fall in the same cycle, that read and the following high read both return the previous result. The new result appears on the next low read.
- R8: A capture sets `irq_o` one cycle later. `irq_level_o` is 5 while `irq_o` is set and 0 otherwise.
- R9: `irq_o` is cleared by `irq_ack_i` or by a low-byte read. A capture in the same cycle as either one keeps `irq_o` set.
- R10: After reset the result, the stale flag, the hold register and `irq_o` are zero. `rd_data_o` is zero whenever `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase clock, 1000 times the signal frequency |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference strobe; a rising edge starts a count |
| sig_i | input | 1 | Signal square wave; a rising edge stops the count |
| rd_i | input | 1 | Read strobe |
| rd_hi_i | input | 1 | Byte select: 0 selects the low byte, 1 the high byte |
| rd_data_o | output | 8 | Read data; zero when rd_i is low |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| irq_o | output | 1 | Interrupt request pending |
| irq_level_o | output | 3 | Priority level of the request (5 while pending, otherwise 0) |

## Verification
A capture can fall in the same cycle as a low-byte read, and in the same cycle as an interrupt acknowledge. The bench provokes both cases by raising the read strobe, or the acknowledge, on the exact phase clock in which the signal edge is sampled. It then judges the outcome against its model: the old result must appear in both bytes of that read pair, the new result must appear on the next pair, and the request must stay set after each collision.

// File: rtl/phase_meter_pkg.sv
package phase_meter_pkg;
  localparam int unsigned CYCLE_COUNT = 1000;
  localparam int unsigned RES_W       = 12;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned IRQ_LEVEL   = 5;
  localparam int unsigned LVL_W       = 3;

  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/phase_edge_det.sv
module phase_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= in_i[g];
    end
    assign rise_o[g] = in_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int unsigned CYCLE_COUNT = 1000,
  parameter int unsigned RES_W       = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_rise_i,
  input  logic             sig_rise_i,
  output logic             cap_valid_o,
  output logic             cap_stale_o,
  output logic [RES_W-1:0] cap_value_o
);
  localparam int unsigned CNT_W = $clog2(CYCLE_COUNT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_COUNT - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             at_last;

  assign at_last     = (cnt_q == LAST);
  assign cap_valid_o = run_q & (sig_rise_i | at_last);
  assign cap_stale_o = run_q & ~sig_rise_i & at_last;
  assign cap_value_o = RES_W'(cnt_q);

  // a reference edge beats an end of count in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (ref_rise_i) begin
      cnt_q <= ONE;
      run_q <= 1'b1;
    end else if (cap_valid_o) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + ONE;
    end
  end
endmodule

// File: rtl/phase_readout.sv
module phase_readout #(
  parameter int unsigned RES_W  = 12,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_valid_i,
  input  logic              cap_stale_i,
  input  logic [RES_W-1:0]  cap_value_i,
  input  logic              rd_i,
  input  logic              rd_hi_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              low_rd_o
);
  import phase_meter_pkg::*;

  localparam int unsigned HI_W  = RES_W - BYTE_W;
  localparam int unsigned PAD_W = BYTE_W - HI_W - 1;

  logic [RES_W-1:0] result_q;
  logic             stale_q;
  logic [HI_W-1:0]  hold_q;
  logic             hold_stale_q;
  byte_sel_e        sel;

  assign sel      = byte_sel_e'(rd_hi_i);
  assign low_rd_o = rd_i & (sel == SEL_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      stale_q  <= 1'b0;
    end else if (cap_valid_i) begin
      result_q <= cap_value_i;
      stale_q  <= cap_stale_i;
    end
  end

  // snapshot takes pre-capture contents, so a pair stays coherent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q       <= '0;
      hold_stale_q <= 1'b0;
    end else if (low_rd_o) begin
      hold_q       <= result_q[RES_W-1:BYTE_W];
      hold_stale_q <= stale_q;
    end
  end

  always_comb begin
    if (!rd_i)                rd_data_o = '0;
    else if (sel == SEL_HI)   rd_data_o = {hold_stale_q, {PAD_W{1'b0}}, hold_q};
    else                      rd_data_o = result_q[BYTE_W-1:0];
  end
endmodule

// File: rtl/phase_irq.sv
module phase_irq #(
  parameter int unsigned LEVEL = 5,
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             ack_i,
  input  logic             clr_i,
  output logic             irq_o,
  output logic [LVL_W-1:0] level_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pend_q <= 1'b0;
    else if (set_i)           pend_q <= 1'b1;
    else if (ack_i || clr_i)  pend_q <= 1'b0;
  end

  assign irq_o   = pend_q;
  assign level_o = pend_q ? LVL_W'(LEVEL) : '0;
endmodule

// File: rtl/phase_meter.sv
module phase_meter #(
  parameter int unsigned CYCLE_COUNT = phase_meter_pkg::CYCLE_COUNT,
  parameter int unsigned RES_W       = phase_meter_pkg::RES_W,
  parameter int unsigned BYTE_W      = phase_meter_pkg::BYTE_W,
  parameter int unsigned IRQ_LEVEL   = phase_meter_pkg::IRQ_LEVEL,
  parameter int unsigned LVL_W       = phase_meter_pkg::LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_i,
  input  logic              sig_i,
  input  logic              rd_i,
  input  logic              rd_hi_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              irq_ack_i,
  output logic              irq_o,
  output logic [LVL_W-1:0]  irq_level_o
);
  logic [1:0]       rise;
  logic             cap_valid;
  logic             cap_stale;
  logic [RES_W-1:0] cap_value;
  logic             low_rd;

  phase_edge_det #(.N(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   ({sig_i, ref_i}),
    .rise_o (rise)
  );

  phase_counter #(.CYCLE_COUNT(CYCLE_COUNT), .RES_W(RES_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_rise_i  (rise[0]),
    .sig_rise_i  (rise[1]),
    .cap_valid_o (cap_valid),
    .cap_stale_o (cap_stale),
    .cap_value_o (cap_value)
  );

  phase_readout #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_valid_i (cap_valid),
    .cap_stale_i (cap_stale),
    .cap_value_i (cap_value),
    .rd_i        (rd_i),
    .rd_hi_i     (rd_hi_i),
    .rd_data_o   (rd_data_o),
    .low_rd_o    (low_rd)
  );

  phase_irq #(.LEVEL(IRQ_LEVEL), .LVL_W(LVL_W)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (cap_valid),
    .ack_i   (irq_ack_i),
    .clr_i   (low_rd),
    .irq_o   (irq_o),
    .level_o (irq_level_o)
  );
endmodule

// File: rtl/phase_meter_chk.sv
module phase_meter_chk #(
  parameter int unsigned CYCLE_COUNT = 1000,
  parameter int unsigned RES_W       = 12,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned IRQ_LEVEL   = 5,
  parameter int unsigned LVL_W       = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              rd_hi_i,
  input logic [BYTE_W-1:0] rd_data_o,
  input logic              irq_ack_i,
  input logic              irq_o,
  input logic [LVL_W-1:0]  irq_level_o,
  input logic              cap_valid,
  input logic              cap_stale,
  input logic [RES_W-1:0]  cap_value
);
  localparam int unsigned HI_W = RES_W - BYTE_W;

  assert_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid |-> (cap_value >= RES_W'(1)) && (cap_value <= RES_W'(CYCLE_COUNT - 1)));

  assert_stale_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_stale |-> cap_valid && (cap_value == RES_W'(CYCLE_COUNT - 1)));

  assert_pad_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rd_hi_i) |-> (rd_data_o[BYTE_W-2:HI_W] == '0));

  assert_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid |=> irq_o && (irq_level_o == LVL_W'(IRQ_LEVEL)));

  assert_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_level_o == '0));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !cap_valid && (irq_ack_i || (rd_i && !rd_hi_i))) |=> !irq_o);

  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rd_data_o == '0));
endmodule

bind phase_meter phase_meter_chk #(
  .CYCLE_COUNT(CYCLE_COUNT), .RES_W(RES_W), .BYTE_W(BYTE_W),
  .IRQ_LEVEL(IRQ_LEVEL), .LVL_W(LVL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_i        (rd_i),
  .rd_hi_i     (rd_hi_i),
  .rd_data_o   (rd_data_o),
  .irq_ack_i   (irq_ack_i),
  .irq_o       (irq_o),
  .irq_level_o (irq_level_o),
  .cap_valid   (cap_valid),
  .cap_stale   (cap_stale),
  .cap_value   (cap_value)
);

// File: tb/phase_meter_test.sv
`timescale 1ns/1ps
module phase_meter_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_i = 1'b0, sig_i = 1'b0, rd_i = 1'b0, rd_hi_i = 1'b0, irq_ack_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       irq_o;
  logic [2:0] irq_level_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] lo, hi, coin_lo;

  always #2 clk_i = ~clk_i;

  phase_meter uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i), .sig_i(sig_i),
    .rd_i(rd_i), .rd_hi_i(rd_hi_i), .rd_data_o(rd_data_o),
    .irq_ack_i(irq_ack_i), .irq_o(irq_o), .irq_level_o(irq_level_o)
  );

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_res, m_hold;
  bit m_run, m_stale, m_irq, m_hold_st, m_ref_d, m_sig_d;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_res = 0; m_hold = 0; m_run = 0; m_stale = 0;
      m_irq = 0; m_hold_st = 0; m_ref_d = 0; m_sig_d = 0;
    end else begin
      bit rr, sr, cap, cst, lrd;
      int cval;
      rr = ref_i && !m_ref_d;
      sr = sig_i && !m_sig_d;
      m_ref_d = ref_i; m_sig_d = sig_i;
      cap = 0; cst = 0; cval = 0;
      if (m_run && sr)               begin cap = 1; cval = m_cnt; end
      else if (m_run && m_cnt == 999) begin cap = 1; cval = 999; cst = 1; end
      lrd = rd_i && !rd_hi_i;
      if (lrd) begin m_hold = (m_res >> 8) & 15; m_hold_st = m_stale; end
      if (cap) begin m_res = cval; m_stale = cst; end
      if (cap) m_irq = 1; else if (irq_ack_i || lrd) m_irq = 0;
      if (rr)       begin m_run = 1; m_cnt = 1; end
      else if (cap) begin m_run = 0; m_cnt = 0; end
      else if (m_run) m_cnt++;
    end
  end

  function automatic int exp_rd();
    if (!rd_i) return 0;
    if (rd_hi_i) return (int'(m_hold_st) << 7) | m_hold;
    return m_res & 255;
  endfunction

  always @(negedge clk_i) begin
    #1;
    if (rst_ni) begin
      chk("R8 irq per-cycle", irq_o, m_irq);
      chk("R8 level per-cycle", irq_level_o, m_irq ? 5 : 0);
      chk("R5 data per-cycle", rd_data_o, exp_rd());
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic meas(int k, bit with_ack, bit with_low);
    @(negedge clk_i) ref_i = 1;
    for (int i = 1; i <= k; i++) begin
      @(negedge clk_i);
      if (i == 1) ref_i = 0;
      if (i == k) begin
        sig_i = 1; irq_ack_i = with_ack;
        if (with_low) begin rd_i = 1; rd_hi_i = 0; #1 coin_lo = rd_data_o; end
      end
    end
    @(negedge clk_i) begin sig_i = 0; irq_ack_i = 0; rd_i = 0; end
    #1;
  endtask

  task automatic rd_pair();
    @(negedge clk_i) begin rd_i = 1; rd_hi_i = 0; end
    #1 lo = rd_data_o;
    @(negedge clk_i) rd_hi_i = 1;
    #1 hi = rd_data_o;
    @(negedge clk_i) begin rd_i = 0; rd_hi_i = 0; end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    chk("R10 reset irq", irq_o, 0);
    chk("R10 reset level", irq_level_o, 0);
    chk("R10 idle data", rd_data_o, 0);
    rd_pair();
    chk("R10 reset low", lo, 0);
    chk("R10 reset high", hi, 0);

    meas(250, 0, 0);
    chk("R8 irq after capture", irq_o, 1);
    chk("R8 level 5", irq_level_o, 5);
    rd_pair();
    chk("R1 k=250 low", lo, 250);
    chk("R6 k=250 high", hi, 0);
    chk("R9 low read clears irq", irq_o, 0);

    meas(1, 0, 0);
    rd_pair();
    chk("R1 k=1 low", lo, 1);

    meas(700, 0, 0);
    rd_pair();
    chk("R5 k=700 low", lo, 8'hBC);
    chk("R6 k=700 high", hi, 8'h02);

    // capture and low read in one cycle
    meas(261, 0, 1);
    chk("R7 coincident low old", coin_lo, 8'hBC);
    chk("R9 capture beats read clear", irq_o, 1);
    @(negedge clk_i) begin rd_i = 1; rd_hi_i = 1; end
    #1 chk("R7 following high old", rd_data_o, 8'h02);
    @(negedge clk_i) begin rd_i = 0; rd_hi_i = 0; end
    rd_pair();
    chk("R7 new low", lo, 8'h05);
    chk("R7 new high", hi, 8'h01);

    // capture and ack in one cycle
    meas(50, 1, 0);
    chk("R9 capture beats ack", irq_o, 1);
    @(negedge clk_i) irq_ack_i = 1;
    @(negedge clk_i) irq_ack_i = 0;
    #1 chk("R9 ack clears", irq_o, 0);
    chk("R8 level 0 idle", irq_level_o, 0);

    // stray signal edge while idle
    @(negedge clk_i) sig_i = 1;
    @(negedge clk_i) sig_i = 0;
    repeat (3) @(negedge clk_i);
    #1 chk("R4 stray edge no irq", irq_o, 0);
    rd_pair();
    chk("R4 result kept", lo, 50);

    // restart by second reference edge
    @(negedge clk_i) ref_i = 1;
    for (int i = 1; i <= 300; i++) begin
      @(negedge clk_i);
      if (i == 1 || i == 101) ref_i = 0;
      if (i == 100) ref_i = 1;
      if (i == 300) sig_i = 1;
    end
    @(negedge clk_i) sig_i = 0;
    rd_pair();
    chk("R3 restart result", lo, 200);

    // timeout
    @(negedge clk_i) ref_i = 1;
    @(negedge clk_i) ref_i = 0;
    repeat (1005) @(negedge clk_i);
    #1 chk("R2 timeout irq", irq_o, 1);
    rd_pair();
    chk("R2 timeout low", lo, 8'hE7);
    chk("R2 timeout high stale", hi, 8'h83);

    meas(999, 0, 0);
    rd_pair();
    chk("R2 edge at 999 low", lo, 8'hE7);
    chk("R2 edge at 999 no stale", hi, 8'h03);

    repeat (4) @(negedge clk_i);
    summary();
    $finish;
  end
endmodule